// File: doc/BRIEF.md
# Two-Bank GPIO Port Register Controller

This block is the register side of a general-purpose I/O port with up to 64 pins. The default is 40. Software uses a simple register bus to write output data, output enable and open-drain settings, and to read back the synchronized pad inputs. Pins 0 to 31 sit in the low bank. The pins above 31 sit in a separate high bank, where pin 32+k is bit k of the high-bank registers.

Output data and output enable can each be written whole. They can also be changed through a set alias and a clear alias, so one write can raise or drop a subset of pins without a read-modify-write. Each pin drives its pad in one of two ways:

- **Push-pull:** the pad follows the data and enable bits directly.
- **Open-drain:** the pad is pulled low only when the pin is enabled and its data bit is 0; otherwise it is released.

Pad inputs pass through a two-stage synchronizer. The result is gated by a per-pin input enable before it reaches the input register and the `pin_in` port.

There is no sequencing state. The block is a bank of registers with combinational pad logic and a registered read port. The register map uses word addresses, given as `bus_addr`. `bus_addr[3]` selects the bank (0 = low, 1 = high), and `bus_addr[2:0]` selects the function:

| Code | Function |
|------|----------|
| 0 | data |
| 1 | data-set alias |
| 2 | data-clear alias |
| 3 | enable |
| 4 | enable-set alias |
| 5 | enable-clear alias |
| 6 | input (read-only) |
| 7 | open-drain |

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every data, enable and open-drain bit is 0, every address reads 0 while pad inputs are low, and `pad_oe` is all zeros.
- R2: A write to function 0, 3 or 7 replaces the data, enable or open-drain bits of the addressed bank with `bus_wdata`, and a later read of the same address returns them.
- R3: A write to a set alias (function 1 or 4) sets each bit that is 1 in `bus_wdata` and leaves the bits that are 0 unchanged.
- R4: A write to a clear alias (function 2 or 5) clears each bit that is 1 in `bus_wdata` and leaves the bits that are 0 unchanged.
- R5: A read of a set or clear alias returns the current value of the register behind it (data for 1 and 2, enable for 4 and 5).
- R6: In the high bank, bit k controls pin 32+k. Write bits at positions of NUM_PINS-32 and above are ignored, and those positions always read 0.
- R7: For a pin with open-drain off, `pad_out` equals its data bit and `pad_oe` equals its enable bit.
- R8: For a pin with open-drain on, `pad_out` is 0 and `pad_oe` is 1 only when its enable bit is 1 and its data bit is 0.
- R9: A change on `pad_in` reaches `pin_in` after two rising clock edges, with no change after only one. The input register (function 6) returns `pin_in` for its bank.
- R10: For a pin with `pin_ie` low, `pin_in` and its bit in the input register are 0 whatever the pad level.
- R11: `bus_rdata` is loaded at the rising edge where `bus_rd` is high and holds its value on every other edge, including edges where only a write occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe, data on `bus_rdata` after the edge |
| bus_addr | input | 4 | Word address: bit 3 bank, bits 2:0 function |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PINS | Raw pad levels, asynchronous |
| pin_ie | input | NUM_PINS | Per-pin input enable |
| pad_out | output | NUM_PINS | Pad output level |
| pad_oe | output | NUM_PINS | Pad output enable |
| pin_in | output | NUM_PINS | Synchronized, enable-gated input |

## Verification
The bench builds the block with the default NUM_PINS of 40. This leaves a high bank 8 bits wide, so writes with bits 8 and above set can show that the unused high-bank positions are ignored and read as 0. It also means every pad vector spans both banks, so push-pull and open-drain pad checks cover pins on either side of the bank boundary in the same comparison.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 4;

    typedef enum logic [2:0] {
        FN_DATA     = 3'd0,
        FN_DATA_SET = 3'd1,
        FN_DATA_CLR = 3'd2,
        FN_EN       = 3'd3,
        FN_EN_SET   = 3'd4,
        FN_EN_CLR   = 3'd5,
        FN_INPUT    = 3'd6,
        FN_OD       = 3'd7
    } gpio_fn_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= raw_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;

    AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sync_o == $past(stage1_q)) else $error("sync stage skipped"); // R9
endmodule

// File: rtl/gpio_bank_slice.sv
module gpio_bank_slice
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  gpio_fn_e     fn,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pad_in_i,
    input  logic [W-1:0] ie_i,
    output logic [W-1:0] rd_val,
    output logic [W-1:0] pad_out_o,
    output logic [W-1:0] pad_oe_o,
    output logic [W-1:0] pin_in_o
);
    logic [W-1:0] out_q;
    logic [W-1:0] oe_q;
    logic [W-1:0] od_q;
    logic [W-1:0] sync_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            oe_q  <= '0;
            od_q  <= '0;
        end else if (wr_en) begin
            case (fn)
                FN_DATA:     out_q <= wdata;
                FN_DATA_SET: out_q <= out_q | wdata;
                FN_DATA_CLR: out_q <= out_q & ~wdata;
                FN_EN:       oe_q  <= wdata;
                FN_EN_SET:   oe_q  <= oe_q | wdata;
                FN_EN_CLR:   oe_q  <= oe_q & ~wdata;
                FN_OD:       od_q  <= wdata;
                default:     ;
            endcase
        end
    end

    gpio_in_sync #(.W(W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pad_in_i),
        .sync_o (sync_in)
    );

    assign pin_in_o = sync_in & ie_i;

    for (genvar i = 0; i < W; i++) begin : g_pad
        always_comb begin
            if (od_q[i]) begin
                pad_out_o[i] = 1'b0;
                pad_oe_o[i]  = oe_q[i] & ~out_q[i];
            end else begin
                pad_out_o[i] = out_q[i];
                pad_oe_o[i]  = oe_q[i];
            end
        end
    end

    always_comb begin
        case (fn)
            FN_DATA, FN_DATA_SET, FN_DATA_CLR: rd_val = out_q;
            FN_EN, FN_EN_SET, FN_EN_CLR:       rd_val = oe_q;
            FN_INPUT:                          rd_val = pin_in_o;
            default:                           rd_val = od_q;
        endcase
    end

    AST_SET_KEEPS_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fn == FN_DATA_SET) |=> out_q == ($past(out_q) | $past(wdata))) else $error("set alias"); // R3
    AST_CLR_KEEPS_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fn == FN_EN_CLR) |=> oe_q == ($past(oe_q) & ~$past(wdata))) else $error("clear alias"); // R4
    AST_OD_NO_HIGH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((od_q & pad_out_o) == '0) && ((od_q & pad_oe_o & out_q) == '0)) else $error("open-drain drove high"); // R8
    AST_IN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_in_o & ~ie_i) == '0) else $error("input not gated"); // R10
    AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(out_q) && $stable(oe_q) && $stable(od_q)) else $error("spurious update"); // R2
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic [NUM_PINS-1:0] pin_ie,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pin_in
);
    localparam int LO_W = BUS_W;
    localparam int HI_W = NUM_PINS - LO_W;

    initial begin
        if (HI_W < 1 || HI_W > BUS_W) $error("NUM_PINS must be 33..64");
    end

    logic     sel_hi;
    gpio_fn_e fn;
    logic [LO_W-1:0] lo_rd;
    logic [HI_W-1:0] hi_rd;

    assign sel_hi = bus_addr[ADDR_W-1];
    assign fn     = gpio_fn_e'(bus_addr[ADDR_W-2:0]);

    gpio_bank_slice #(.W(LO_W)) u_lo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr && !sel_hi),
        .fn        (fn),
        .wdata     (bus_wdata),
        .pad_in_i  (pad_in[LO_W-1:0]),
        .ie_i      (pin_ie[LO_W-1:0]),
        .rd_val    (lo_rd),
        .pad_out_o (pad_out[LO_W-1:0]),
        .pad_oe_o  (pad_oe[LO_W-1:0]),
        .pin_in_o  (pin_in[LO_W-1:0])
    );

    gpio_bank_slice #(.W(HI_W)) u_hi (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr && sel_hi),
        .fn        (fn),
        .wdata     (bus_wdata[HI_W-1:0]),
        .pad_in_i  (pad_in[NUM_PINS-1:LO_W]),
        .ie_i      (pin_ie[NUM_PINS-1:LO_W]),
        .rd_val    (hi_rd),
        .pad_out_o (pad_out[NUM_PINS-1:LO_W]),
        .pad_oe_o  (pad_oe[NUM_PINS-1:LO_W]),
        .pin_in_o  (pin_in[NUM_PINS-1:LO_W])
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= sel_hi ? BUS_W'(hi_rd) : lo_rd;
        end
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)) else $error("read data moved"); // R11
    AST_HI_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && sel_hi) |-> (bus_rdata >> HI_W) == '0) else $error("high bank upper bits"); // R6
endmodule

// File: tb/sim_gpio_bank_ctrl.sv
module sim_gpio_bank_ctrl;
    localparam int N = 40;
    localparam int NV = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pin_ie = '0;
    logic [N-1:0]  pad_out;
    logic [N-1:0]  pad_oe;
    logic [N-1:0]  pin_in;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    gpio_bank_ctrl #(.NUM_PINS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pin_ie(pin_ie), .pad_out(pad_out),
        .pad_oe(pad_oe), .pin_in(pin_in)
    );

    // {req, write addr, write data, read addr, expected}
    localparam logic [75:0] VEC [NV] = '{
        {4'd2, 4'h0, 32'hA5A5_0F0F, 4'h0, 32'hA5A5_0F0F},
        {4'd3, 4'h1, 32'h0000_F000, 4'h0, 32'hA5A5_FF0F},
        {4'd4, 4'h2, 32'hA000_000F, 4'h1, 32'h05A5_FF00},
        {4'd2, 4'h3, 32'hFFFF_0000, 4'h3, 32'hFFFF_0000},
        {4'd3, 4'h4, 32'h0000_00FF, 4'h5, 32'hFFFF_00FF},
        {4'd4, 4'h5, 32'h0F00_0001, 4'h3, 32'hF0FF_00FE},
        {4'd6, 4'h8, 32'hFFFF_FFFF, 4'h8, 32'h0000_00FF},
        {4'd4, 4'hA, 32'h0000_0F0F, 4'h8, 32'h0000_00F0},
        {4'd5, 4'h9, 32'h0000_0001, 4'hA, 32'h0000_00F1},
        {4'd5, 4'hB, 32'h0000_003C, 4'hD, 32'h0000_003C},
        {4'd6, 4'hC, 32'h0000_01C0, 4'hB, 32'h0000_00FC},
        {4'd2, 4'hF, 32'h0000_00FF, 4'hF, 32'h0000_00FF},
        {4'd2, 4'h7, 32'h0000_FFFF, 4'h7, 32'h0000_FFFF}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [2*N-1:0] pad_model(input logic [N-1:0] o,
                                                 input logic [N-1:0] e,
                                                 input logic [N-1:0] d);
        logic [N-1:0] po, pe;
        for (int i = 0; i < N; i++) begin
            po[i] = d[i] ? 1'b0 : o[i];
            pe[i] = d[i] ? (e[i] & ~o[i]) : e[i];
        end
        return {po, pe};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        logic [N-1:0] o_m, e_m, d_m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: everything reads zero after reset
        for (int a = 0; a < 16; a++) begin
            bus_read(a[3:0], rd);
            check("R1 reset readback", 64'(rd), 64'h0);
        end
        check("R1 pad_oe after reset", 64'(pad_oe), 64'h0);

        // table walk: R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            bus_write(VEC[v][71:68], VEC[v][67:36]);
            bus_read(VEC[v][35:32], rd);
            checks++;
            if (rd !== VEC[v][31:0]) begin
                failures++;
                $display("FAIL R%0d vector %0d actual=%h expected=%h",
                         VEC[v][75:72], v, rd, VEC[v][31:0]);
            end
        end

        // R8: open-drain on all low pins 0..15 and all high pins
        o_m = {8'hF1, 32'h05A5_FF00};
        e_m = {8'hFC, 32'hF0FF_00FE};
        d_m = {8'hFF, 32'h0000_FFFF};
        check("R8 open-drain pads", 64'({pad_out, pad_oe}), 64'(pad_model(o_m, e_m, d_m)));
        check("R8 high pad_oe", 64'(pad_oe[39:32]), 64'h0C);

        // R7: push-pull after clearing high open-drain
        bus_write(4'hF, 32'h0);
        d_m = {8'h00, 32'h0000_FFFF};
        check("R7 push-pull high pad_out", 64'(pad_out[39:32]), 64'hF1);
        check("R7 push-pull high pad_oe", 64'(pad_oe[39:32]), 64'hFC);
        check("R7 mixed pads", 64'({pad_out, pad_oe}), 64'(pad_model(o_m, e_m, d_m)));

        // R9: two-edge synchronizer latency
        pin_ie = '1;
        @(negedge clk);
        pad_in = {8'h5A, 32'hDEAD_BEEF};
        @(negedge clk);
        check("R9 one edge no change", 64'(pin_in), 64'h0);
        @(negedge clk);
        check("R9 two edges visible", 64'(pin_in), 64'h5A_DEAD_BEEF);
        bus_read(4'h6, rd);
        check("R9 low input reg", 64'(rd), 64'hDEAD_BEEF);
        bus_read(4'hE, rd);
        check("R9 high input reg", 64'(rd), 64'h5A);

        // R10: input enable gating
        pin_ie = {8'h0F, 32'h0000_FFFF};
        @(negedge clk);
        check("R10 gated pin_in", 64'(pin_in), 64'h0A_0000_BEEF);
        bus_read(4'h6, rd);
        check("R10 gated low reg", 64'(rd), 64'h0000_BEEF);

        // R11: read data holds across a write-only cycle
        bus_read(4'h3, rd);
        bus_write(4'h3, 32'h1234_5678);
        check("R11 rdata held", 64'(bus_rdata), 64'hF0FF_00FE);
        bus_read(4'h4, rd);
        check("R11 R5 new read after write", 64'(rd), 64'h1234_5678);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule